// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

This block sits between a time-division multiplexed serial line and a set of serial controllers. It holds two small route tables, one for the receive direction and one for the transmit direction. Each table is a list of entries. After a frame sync, each table walks its entries in order. Every entry covers a run of bits, or of whole bytes. For that run the entry names the controller port that takes the received bits, or that supplies the bits to send. It also gives the level of four strobe outputs. An entry can mark its run as unrouted, or as driven with idle ones.

The receive table clocks on the receive line clock and the transmit table on the transmit line clock. A receive entry can swap the two data pins for its run: outgoing data then leaves on the receive pin and incoming data is taken from the transmit pin. Each data pin is split into a value input, a value output and an output enable. Software loads the tables through a plain write port, and only while the block is disabled. Enabling the block arms both tables. Each table starts at entry 0 on its next frame sync and, after its last entry, stays idle until the next sync.

Entry layout (16 bits; bit 0 is the least significant):

| Bits | Meaning |
|------|---------|
| 0 | multichannel flag: 1 routes the run to port 9 and overrides the code |
| 1 | pin swap flag (acted on in receive entries only) |
| 5:2 | strobe levels, bit 2 drives `stb[0]` |
| 6 | reserved, stored as zero |
| 10:7 | channel code |
| 13:11 | run length minus one |
| 14 | byte mode: the run counts bytes of 8 bits |
| 15 | last entry of the table |

Top module: `tdm_route_seq`

## Requirements
- R1: From reset, and after enabling until the first frame sync, `stb` is 0. `txd_oe`, `rxd_oe`, `rx_vld` and `tx_req` are also 0.
- R2: A frame sync seen at a rising clock edge while a table is armed starts entry 0 in the next cycle. Each entry lasts (length field + 1) cycles, or 8 times that in byte mode. After it, the table moves on to the next entry.
- R3: Channel codes 1 to 4 map to ports 0 to 3, codes 5 and 6 to ports 4 and 5, and codes 9 to 11 to ports 6 to 8. When the multichannel flag is set the run goes to port 9 whatever the code. The port gets a one-hot `rx_vld` bit with `rx_dat`, and a one-hot `tx_req` bit, and the pin carries `tx_dat` of that port.
- R4: Codes 0, 8 and 12 to 15 route nothing: the transmit pin is released (`txd_oe` low), no `rx_vld` or `tx_req` bit is set, and `rx_dat` stays 0 whatever the pin carries.
- R5: Code 7 serves no port but drives the transmit pin high.
- R6: A receive entry with the swap flag set moves outgoing data to `rxd_o` under `rxd_oe`, with `txd_oe` low. It also takes incoming data from `txd_i`. The swap flag in a transmit entry has no effect.
- R7: Each `stb` bit is the OR of the strobe bit of the running receive entry and that of the running transmit entry. A strobe set in adjacent entries stays high across the boundary.
- R8: After the last entry (last flag set, or the final table slot) a table's strobes and routes fall at once. A frame sync that arrives while a run is in progress is ignored. The next sync seen while idle restarts the table at entry 0.
- R9: A table write takes effect only while `en` is low. A write while enabled leaves the entry unchanged.
- R10: Dropping `en` stops both tables at the next edge. Raising it again re-arms them to wait for a frame sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | receive line clock |
| tx_clk | input | 1 | transmit line clock |
| rst_n | input | 1 | asynchronous reset, active low |
| en | input | 1 | block enable |
| rx_fsync | input | 1 | receive frame sync |
| tx_fsync | input | 1 | transmit frame sync |
| wr_en | input | 1 | table write strobe |
| wr_tx | input | 1 | 1 selects the transmit table, 0 the receive table |
| wr_addr | input | IDX_W | entry index to write |
| wr_data | input | 16 | entry value |
| rxd_i | input | 1 | receive pin value |
| rxd_o | output | 1 | receive pin drive value (swap) |
| rxd_oe | output | 1 | receive pin output enable |
| txd_i | input | 1 | transmit pin value |
| txd_o | output | 1 | transmit pin drive value |
| txd_oe | output | 1 | transmit pin output enable |
| stb | output | NSTB | strobe outputs |
| rx_dat | output | 1 | received bit for the selected port |
| rx_vld | output | NPORT | one-hot receive port select |
| tx_dat | input | NPORT | per-port transmit bit |
| tx_req | output | NPORT | one-hot transmit port select |

## Verification
The bench loads a frame in which the two tables change entry at different points. This catches a design that steps both tables with one counter, because strobes or routes would then change on the wrong cycle. The frame holds a swapped receive run and a transmit entry whose swap flag must have no effect. A design that honours the wrong table's flag drives the wrong pin, and one that never restores the pins leaves `rx_dat` taken from `txd_i`. A strobe is held across an entry boundary and another is set on the last entry. A late fall would show in the idle cycle, and a wrong restart would show a bad strobe level. A frame sync is raised in the middle of the frame and a table write is made while enabled. Either must leave the next frame intact. Byte mode is checked at the eighth cycle, where a bit-only counter would end the run too early.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;

  localparam int NSTB     = 4;
  localparam int LEN_W    = 3;
  localparam int CODE_W   = 4;
  localparam int NPORT    = 10;
  localparam int PORT_W   = $clog2(NPORT);
  localparam int MCC_PORT = NPORT - 1;
  localparam int CNT_W    = LEN_W + 4;
  localparam int ENTRY_W  = 16;

  typedef struct packed {
    logic              last;
    logic              byte_mode;
    logic [LEN_W-1:0]  len;
    logic [CODE_W-1:0] code;
    logic              rsvd;
    logic [NSTB-1:0]   stb;
    logic              swap;
    logic              mcc;
  } route_ent_t;

  typedef enum logic [1:0] {SEQ_OFF, SEQ_WAIT, SEQ_RUN} seq_st_t;

  typedef struct packed {
    logic              hit;
    logic              ones;
    logic [PORT_W-1:0] port;
  } route_t;

  // Clear the reserved bit on the way into the table.
  function automatic route_ent_t sanitize(input logic [ENTRY_W-1:0] raw);
    route_ent_t e;
    e = route_ent_t'(raw);
    e.rsvd = 1'b0;
    return e;
  endfunction

  // Length of one run in line clock cycles.
  function automatic logic [CNT_W-1:0] group_bits(input route_ent_t e);
    logic [CNT_W-1:0] n;
    n = CNT_W'(e.len) + CNT_W'(1);
    if (e.byte_mode) n = n << 3;
    return n;
  endfunction

  // Map the entry to a controller port, the idle-ones action or nothing.
  function automatic route_t route_of(input route_ent_t e);
    route_t r;
    r = '0;
    if (e.mcc) begin
      r.hit  = 1'b1;
      r.port = PORT_W'(MCC_PORT);
    end else begin
      case (e.code)
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
          r.hit  = 1'b1;
          r.port = PORT_W'(e.code - 4'd1);
        end
        4'd9, 4'd10, 4'd11: begin
          r.hit  = 1'b1;
          r.port = PORT_W'(e.code - 4'd3);
        end
        4'd7:    r.ones = 1'b1;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table
  import tdm_route_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter bit IS_RX = 1'b1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fsync,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  route_ent_t       wr_ent,
  output logic             run,
  output logic             fin,
  output route_ent_t       cur,
  output logic [NSTB-1:0]  stb,
  output logic             swap
);

  route_ent_t       ram [DEPTH];
  seq_st_t          st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             grp_end;
  logic             last_ent;

  assign cur      = ram[idx];
  assign run      = (st == SEQ_RUN);
  assign grp_end  = (cnt == group_bits(cur) - CNT_W'(1));
  assign last_ent = cur.last || (idx == IDX_W'(DEPTH - 1));
  assign fin      = run && grp_end && last_ent;
  assign stb      = run ? cur.stb : '0;

  generate
    if (IS_RX) begin : g_swap
      assign swap = run && cur.swap;
    end else begin : g_noswap
      assign swap = 1'b0;
    end
  endgenerate

  // Entry storage: loaded only while the block is disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else if (wr_en && !en) begin
      ram[wr_addr] <= wr_ent;
    end
  end

  // Sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SEQ_OFF;
      idx <= '0;
      cnt <= '0;
    end else if (!en) begin
      st  <= SEQ_OFF;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (st)
        SEQ_OFF: begin
          st  <= SEQ_WAIT;
          idx <= '0;
          cnt <= '0;
        end
        SEQ_WAIT: begin
          idx <= '0;
          cnt <= '0;
          if (fsync) st <= SEQ_RUN;
        end
        SEQ_RUN: begin
          if (grp_end) begin
            cnt <= '0;
            if (last_ent) begin
              st  <= SEQ_WAIT;
              idx <= '0;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= SEQ_OFF;
      endcase
    end
  end

endmodule

// File: rtl/tdm_route_pinmux.sv
module tdm_route_pinmux
  import tdm_route_pkg::*;
(
  input  logic             rx_run,
  input  route_ent_t       rx_ent,
  input  logic             rx_swap,
  input  logic             tx_run,
  input  route_ent_t       tx_ent,
  input  logic             rxd_i,
  input  logic             txd_i,
  input  logic [NPORT-1:0] tx_dat,
  output logic             rxd_o,
  output logic             rxd_oe,
  output logic             txd_o,
  output logic             txd_oe,
  output logic             rx_dat,
  output logic [NPORT-1:0] rx_vld,
  output logic [NPORT-1:0] tx_req
);

  route_t rx_rt;
  route_t tx_rt;
  logic   src_bit;
  logic   tx_bit;
  logic   tx_drv;

  assign rx_rt = route_of(rx_ent);
  assign tx_rt = route_of(tx_ent);

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign rx_vld[p] = rx_run && rx_rt.hit && (rx_rt.port == PORT_W'(p));
      assign tx_req[p] = tx_run && tx_rt.hit && (tx_rt.port == PORT_W'(p));
    end
  endgenerate

  assign src_bit = rx_swap ? txd_i : rxd_i;
  assign rx_dat  = (|rx_vld) && src_bit;

  assign tx_drv  = tx_run && (tx_rt.hit || tx_rt.ones);
  assign tx_bit  = tx_rt.ones || (|(tx_req & tx_dat));
  assign txd_oe  = tx_drv && !rx_swap;
  assign rxd_oe  = tx_drv && rx_swap;
  assign txd_o   = txd_oe && tx_bit;
  assign rxd_o   = rxd_oe && tx_bit;

endmodule

// File: rtl/tdm_route_seq.sv
module tdm_route_seq
  import tdm_route_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               rx_clk,
  input  logic               tx_clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               rx_fsync,
  input  logic               tx_fsync,
  input  logic               wr_en,
  input  logic               wr_tx,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rxd_i,
  output logic               rxd_o,
  output logic               rxd_oe,
  input  logic               txd_i,
  output logic               txd_o,
  output logic               txd_oe,
  output logic [NSTB-1:0]    stb,
  output logic               rx_dat,
  output logic [NPORT-1:0]   rx_vld,
  input  logic [NPORT-1:0]   tx_dat,
  output logic [NPORT-1:0]   tx_req
);

  route_ent_t      wr_ent;
  route_ent_t      rx_ent;
  route_ent_t      tx_ent;
  logic            rx_run, tx_run;
  logic            rx_fin, tx_fin;
  logic            rx_swap, tx_swap;
  logic [NSTB-1:0] rx_stb_v, tx_stb_v;

  assign wr_ent = sanitize(wr_data);

  tdm_route_table #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_tbl (
    .clk     (rx_clk),
    .rst_n   (rst_n),
    .en      (en),
    .fsync   (rx_fsync),
    .wr_en   (wr_en && !wr_tx),
    .wr_addr (wr_addr),
    .wr_ent  (wr_ent),
    .run     (rx_run),
    .fin     (rx_fin),
    .cur     (rx_ent),
    .stb     (rx_stb_v),
    .swap    (rx_swap)
  );

  tdm_route_table #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_tbl (
    .clk     (tx_clk),
    .rst_n   (rst_n),
    .en      (en),
    .fsync   (tx_fsync),
    .wr_en   (wr_en && wr_tx),
    .wr_addr (wr_addr),
    .wr_ent  (wr_ent),
    .run     (tx_run),
    .fin     (tx_fin),
    .cur     (tx_ent),
    .stb     (tx_stb_v),
    .swap    (tx_swap)
  );

  assign stb = rx_stb_v | tx_stb_v;

  tdm_route_pinmux u_pinmux (
    .rx_run  (rx_run),
    .rx_ent  (rx_ent),
    .rx_swap (rx_swap),
    .tx_run  (tx_run),
    .tx_ent  (tx_ent),
    .rxd_i   (rxd_i),
    .txd_i   (txd_i),
    .tx_dat  (tx_dat),
    .rxd_o   (rxd_o),
    .rxd_oe  (rxd_oe),
    .txd_o   (txd_o),
    .txd_oe  (txd_oe),
    .rx_dat  (rx_dat),
    .rx_vld  (rx_vld),
    .tx_req  (tx_req)
  );

endmodule

// File: rtl/tdm_route_chk.sv
module tdm_route_chk
  import tdm_route_pkg::*;
(
  input logic             rx_clk,
  input logic             tx_clk,
  input logic             rst_n,
  input logic             en,
  input logic             rx_run,
  input logic             tx_run,
  input logic             rx_fin,
  input logic             tx_fin,
  input logic             rxd_oe,
  input logic             txd_oe,
  input logic             rx_dat,
  input logic [NSTB-1:0]  stb,
  input logic [NPORT-1:0] rx_vld,
  input logic [NPORT-1:0] tx_req
);

  // R1
  rx_idle_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !rx_run |-> (rx_vld == '0));

  // R1
  tx_idle_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    !tx_run |-> (!txd_oe && !rxd_oe && tx_req == '0));

  // R3
  vld_onehot_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    $onehot0(rx_vld));

  // R3
  req_onehot_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    $onehot0(tx_req));

  // R4
  discard_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_dat |-> (rx_vld != '0));

  // R6
  pin_excl_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    !(txd_oe && rxd_oe));

  // R7
  stb_idle_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (!rx_run && !tx_run) |-> (stb == '0));

  // R8
  rx_fin_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_fin |=> !rx_run);

  // R8
  tx_fin_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_fin |=> !tx_run);

  // R10
  off_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !en |=> !rx_run);

endmodule

bind tdm_route_seq tdm_route_chk u_chk (
  .rx_clk (rx_clk),
  .tx_clk (tx_clk),
  .rst_n  (rst_n),
  .en     (en),
  .rx_run (rx_run),
  .tx_run (tx_run),
  .rx_fin (rx_fin),
  .tx_fin (tx_fin),
  .rxd_oe (rxd_oe),
  .txd_oe (txd_oe),
  .rx_dat (rx_dat),
  .stb    (stb),
  .rx_vld (rx_vld),
  .tx_req (tx_req)
);

// File: tb/test_tdm_route_seq.sv
module test_tdm_route_seq;

  localparam int DEPTH = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        fsync = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_tx = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rxd_i = 1'b0;
  logic        txd_i = 1'b0;
  logic [9:0]  tx_dat = 10'b00_0000_0010;
  logic        rxd_o, rxd_oe, txd_o, txd_oe, rx_dat;
  logic [3:0]  stb;
  logic [9:0]  rx_vld, tx_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tdm_route_seq #(.DEPTH(DEPTH)) i_tdm_route_seq (
    .rx_clk (clk), .tx_clk (clk), .rst_n (rst_n), .en (en),
    .rx_fsync (fsync), .tx_fsync (fsync),
    .wr_en (wr_en), .wr_tx (wr_tx), .wr_addr (wr_addr), .wr_data (wr_data),
    .rxd_i (rxd_i), .rxd_o (rxd_o), .rxd_oe (rxd_oe),
    .txd_i (txd_i), .txd_o (txd_o), .txd_oe (txd_oe),
    .stb (stb), .rx_dat (rx_dat), .rx_vld (rx_vld),
    .tx_dat (tx_dat), .tx_req (tx_req)
  );

  function automatic logic [15:0] ent(input logic lst, input logic bm,
      input logic [2:0] len, input logic [3:0] code, input logic [3:0] s,
      input logic sw, input logic mc);
    return {lst, bm, len, code, 1'b0, s, sw, mc};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic tx, input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tx = tx; wr_addr = IDX_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_idle(input string req);
    check(req, {25'd0, stb, txd_oe, rxd_oe}, 32'd0);
    check(req, {12'd0, rx_vld, tx_req}, 32'd0);
  endtask

  // {fsync, rxd_i, txd_i, stb, txd_oe, txd_o, rxd_oe, rxd_o, rx_dat, rx_vld, tx_req}
  localparam logic [31:0] VEC [0:5] = '{
    {1'b0, 1'b1, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'b0000000001, 10'b0000010000},
    {1'b0, 1'b0, 1'b1, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'b0000000001, 10'b0000000000},
    {1'b1, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'b0001000000, 10'b0000000010},
    {1'b0, 1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'b1000000000, 10'b0000000010},
    {1'b0, 1'b1, 1'b1, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0000000000, 10'b0000000000},
    {1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0000000000, 10'b0000000000}
  };

  initial begin : watchdog
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    check_idle("R1 reset");
    rst_n = 1'b1;

    // receive table
    wr(1'b0, 0, ent(1'b0, 1'b0, 3'd1, 4'd1,  4'b0001, 1'b0, 1'b0));
    wr(1'b0, 1, ent(1'b0, 1'b0, 3'd0, 4'd9,  4'b0011, 1'b1, 1'b0));
    wr(1'b0, 2, ent(1'b0, 1'b0, 3'd0, 4'd0,  4'b0000, 1'b0, 1'b1));
    wr(1'b0, 3, ent(1'b1, 1'b0, 3'd0, 4'd0,  4'b1000, 1'b0, 1'b0));
    // transmit table (entry 2 carries a swap flag that must be ignored)
    wr(1'b1, 0, ent(1'b0, 1'b0, 3'd0, 4'd5,  4'b0100, 1'b0, 1'b0));
    wr(1'b1, 1, ent(1'b0, 1'b0, 3'd0, 4'd7,  4'b0000, 1'b0, 1'b0));
    wr(1'b1, 2, ent(1'b0, 1'b0, 3'd1, 4'd2,  4'b0000, 1'b1, 1'b0));
    wr(1'b1, 3, ent(1'b1, 1'b0, 3'd0, 4'd13, 4'b0000, 1'b0, 1'b0));

    @(negedge clk);
    en = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check_idle("R1 armed before sync");
    end

    // R9: write while enabled must not land
    wr(1'b0, 0, ent(1'b0, 1'b0, 3'd1, 4'd1, 4'b1111, 1'b0, 1'b0));

    // Frame 1: vector walk (R2 R3 R4 R5 R6 R7 R8, fsync mid-frame ignored)
    @(negedge clk);
    fsync = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fsync = VEC[i][31]; rxd_i = VEC[i][30]; txd_i = VEC[i][29];
      #1;
      check($sformatf("R7 R9 strobes cycle %0d", i), {28'd0, stb}, {28'd0, VEC[i][28:25]});
      check($sformatf("R4 R5 R6 pins cycle %0d", i),
            {27'd0, txd_oe, txd_o, rxd_oe, rxd_o, rx_dat}, {27'd0, VEC[i][24:20]});
      check($sformatf("R2 R3 ports cycle %0d", i), {12'd0, rx_vld, tx_req}, {12'd0, VEC[i][19:0]});
    end
    fsync = 1'b0;
    repeat (2) begin
      @(negedge clk); #1;
      check_idle("R8 idle after last entry");
    end

    // Frame 2: restart at entry 0
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    #1;
    check("R8 restart strobes", {28'd0, stb}, 32'h5);
    check("R8 restart route", {22'd0, tx_req}, 32'h010);
    // R10: drop enable during the frame
    en = 1'b0;
    @(negedge clk); #1;
    check_idle("R10 stopped by disable");
    en = 1'b1;
    repeat (2) begin
      @(negedge clk); #1;
      check_idle("R10 re-armed waits for sync");
    end

    // Byte mode (R2): tx entry 0 is one byte, last
    en = 1'b0;
    wr(1'b1, 0, ent(1'b1, 1'b1, 3'd0, 4'd5, 4'b0100, 1'b0, 1'b0));
    wr(1'b0, 0, ent(1'b1, 1'b0, 3'd0, 4'd8, 4'b0000, 1'b0, 1'b0));
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    fsync = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      fsync = 1'b0;
      rxd_i = 1'b1;
      #1;
      check($sformatf("R2 byte run cycle %0d", i), {22'd0, tx_req},
            (i < 8) ? 32'h010 : 32'h0);
      check($sformatf("R7 byte strobe cycle %0d", i), {28'd0, stb},
            (i < 8) ? 32'h4 : 32'h0);
      if (i == 0)
        check("R4 reserved code discards", {21'd0, rx_dat, rx_vld}, 32'd0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule